// File: doc/BRIEF.md
# Home-Tile Load-Linked / Store-Conditional Reservation Unit

This unit sits at the tile that is home to a group of pages, where each word has exactly one on-chip copy. It takes one request per cycle from any processor. A request is a plain load, a load-linked, a store-conditional or a plain store, and it carries the requester's ID, a word address and write data. The unit holds the local word storage. It answers every request one cycle later with the requester's ID, the read data and a store-conditional verdict. It also exposes the write strobe, address and data it applies to its storage.

Atomic read-modify-write sequences are built on one reservation register shared by every address the tile is home to. The register holds the owning requester's ID, the reserved address and an age counter. Once the register is held, a later load-linked cannot take it over, so competing processors cannot keep stealing it from each other. A reservation whose owner never returns is dropped after a fixed number of cycles, so an abandoned reservation cannot block the unit. A store-conditional writes only when both its requester ID and its address match the register.

Top module: `llsc_home_unit`

## Requirements
- R1: After reset, no reservation is held, `rsp_valid` and `mem_we` are low, and every storage word reads as zero.
- R2: Request opcodes are 0 plain load, 1 load-linked, 2 store-conditional, 3 plain store. A load-linked that finds the register free returns the addressed word and takes the reservation for its ID and address.
- R3: A load-linked that arrives while the register is held still returns the addressed word. It leaves the owner, address and age unchanged, so the refused requester's later store-conditional fails and the owner's still succeeds.
- R4: A store-conditional succeeds only when the reservation is held with the same requester ID and the same address. On success it raises `mem_we` in its request cycle with the request address and data, returns `rsp_sc_ok`=1, and releases the reservation.
- R5: A failed store-conditional leaves `mem_we` low, returns `rsp_sc_ok`=0 and leaves the reservation as it was.
- R6: A plain store always writes. If it hits the reserved address, it releases the reservation whoever sent it. If it goes to any other address, the reservation is kept.
- R7: A reservation lives for TIMEOUT cycles after the accepting edge. A store-conditional sampled TIMEOUT edges after the load-linked succeeds, and one sampled TIMEOUT+1 edges after it fails.
- R8: On the edge where a reservation expires, a load-linked from any requester is accepted in that same cycle.
- R9: Each accepted request produces exactly one response on the next cycle, carrying the request's ID and opcode. Without a request there is no response. Store-conditionals and plain stores return zero read data.
- R10: A plain load returns the addressed word and does not change the reservation.
- R11: The single register covers all addresses. A load-linked to a different address is refused while any reservation is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Opcode: 0 load, 1 load-linked, 2 store-conditional, 3 store |
| req_id | input | ID_W | Requester ID |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data for the two store kinds |
| rsp_valid | output | 1 | Response present |
| rsp_id | output | ID_W | Requester ID echoed |
| rsp_op | output | 2 | Opcode echoed |
| rsp_rdata | output | DATA_W | Word read for load and load-linked, else zero |
| rsp_sc_ok | output | 1 | Store-conditional succeeded |
| mem_we | output | 1 | Storage write strobe in the request cycle |
| mem_addr | output | ADDR_W | Storage write address |
| mem_wdata | output | DATA_W | Storage write data |

## Verification
Two events can fall on the same edge: the expiry of an aged reservation and a new load-linked from a different requester. The bench places a load-linked exactly TIMEOUT edges after an accepted one. It judges the outcome through later store-conditionals: the new requester's must succeed, and the original owner's must fail. The nearby boundary is probed separately, with store-conditionals at exactly TIMEOUT and TIMEOUT+1 edges.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [1:0] {
    OP_LD = 2'd0,
    OP_LL = 2'd1,
    OP_SC = 2'd2,
    OP_ST = 2'd3
  } llsc_op_e;

  typedef struct packed {
    logic ld;
    logic ll;
    logic sc;
    logic st;
  } llsc_kind_t;

endpackage

// File: rtl/llsc_req_decode.sv
module llsc_req_decode
  import llsc_pkg::*;
(
  input  logic       req_valid,
  input  logic [1:0] req_op,
  output llsc_kind_t kind
);

  always_comb begin
    kind = '0;
    if (req_valid) begin
      unique case (llsc_op_e'(req_op))
        OP_LD: kind.ld = 1'b1;
        OP_LL: kind.ll = 1'b1;
        OP_SC: kind.sc = 1'b1;
        OP_ST: kind.st = 1'b1;
        default: kind = '0;
      endcase
    end
  end

endmodule

// File: rtl/llsc_resv_reg.sv
module llsc_resv_reg
  import llsc_pkg::*;
#(
  parameter int ID_W    = 3,
  parameter int ADDR_W  = 6,
  parameter int TIMEOUT = 256,
  localparam int CNT_W  = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  llsc_kind_t        kind,
  input  logic [ID_W-1:0]   req_id,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resv_valid,
  output logic [ID_W-1:0]   resv_id,
  output logic [ADDR_W-1:0] resv_addr,
  output logic [CNT_W-1:0]  resv_count,
  output logic              ll_accept,
  output logic              ll_refuse,
  output logic              sc_pass,
  output logic              sc_fail,
  output logic              st_kill,
  output logic              tmo_fire
);

  // Reservation has aged to its last live cycle.
  function automatic logic at_limit(input logic [CNT_W-1:0] cnt);
    return cnt == CNT_W'(TIMEOUT - 1);
  endfunction

  // Requester owns the reservation at this address.
  function automatic logic owner_match(input logic v,
                                       input logic [ID_W-1:0] rid,
                                       input logic [ADDR_W-1:0] raddr,
                                       input logic [ID_W-1:0] id,
                                       input logic [ADDR_W-1:0] addr);
    return v && (rid == id) && (raddr == addr);
  endfunction

  logic slot_free;

  assign tmo_fire  = resv_valid && at_limit(resv_count);
  assign slot_free = !resv_valid || tmo_fire;
  assign ll_accept = kind.ll && slot_free;
  assign ll_refuse = kind.ll && !slot_free;
  assign sc_pass   = kind.sc && owner_match(resv_valid, resv_id, resv_addr, req_id, req_addr);
  assign sc_fail   = kind.sc && !sc_pass;
  assign st_kill   = kind.st && resv_valid && (resv_addr == req_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_valid <= 1'b0;
      resv_id    <= '0;
      resv_addr  <= '0;
      resv_count <= '0;
    end else if (sc_pass || st_kill) begin
      resv_valid <= 1'b0;
      resv_count <= '0;
    end else if (ll_accept) begin
      resv_valid <= 1'b1;
      resv_id    <= req_id;
      resv_addr  <= req_addr;
      resv_count <= '0;
    end else if (tmo_fire) begin
      resv_valid <= 1'b0;
      resv_count <= '0;
    end else if (resv_valid) begin
      resv_count <= resv_count + 1'b1;
    end
  end

endmodule

// File: rtl/llsc_word_store.sv
module llsc_word_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] words [DEPTH];

  assign rdata = words[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) words[k] <= '0;
    end else if (we) begin
      words[addr] <= wdata;
    end
  end

endmodule

// File: rtl/llsc_home_unit.sv
module llsc_home_unit
  import llsc_pkg::*;
#(
  parameter int ID_W    = 3,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  parameter int TIMEOUT = 256,
  localparam int CNT_W  = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ID_W-1:0]   req_id,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [ID_W-1:0]   rsp_id,
  output logic [1:0]        rsp_op,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_sc_ok,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);

  llsc_kind_t        kind;
  logic              resv_valid;
  logic [ID_W-1:0]   resv_id;
  logic [ADDR_W-1:0] resv_addr;
  logic [CNT_W-1:0]  resv_count;
  logic              ll_accept, ll_refuse, sc_pass, sc_fail, st_kill, tmo_fire;
  logic [DATA_W-1:0] rd_word;

  llsc_req_decode u_decode (
    .req_valid (req_valid),
    .req_op    (req_op),
    .kind      (kind)
  );

  llsc_resv_reg #(.ID_W(ID_W), .ADDR_W(ADDR_W), .TIMEOUT(TIMEOUT)) u_resv (
    .clk        (clk),
    .rst_n      (rst_n),
    .kind       (kind),
    .req_id     (req_id),
    .req_addr   (req_addr),
    .resv_valid (resv_valid),
    .resv_id    (resv_id),
    .resv_addr  (resv_addr),
    .resv_count (resv_count),
    .ll_accept  (ll_accept),
    .ll_refuse  (ll_refuse),
    .sc_pass    (sc_pass),
    .sc_fail    (sc_fail),
    .st_kill    (st_kill),
    .tmo_fire   (tmo_fire)
  );

  assign mem_we    = kind.st || sc_pass;
  assign mem_addr  = req_addr;
  assign mem_wdata = req_wdata;

  llsc_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .addr  (req_addr),
    .wdata (req_wdata),
    .rdata (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
      rsp_op    <= '0;
      rsp_rdata <= '0;
      rsp_sc_ok <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_id    <= req_valid ? req_id : '0;
      rsp_op    <= req_valid ? req_op : '0;
      rsp_rdata <= (kind.ld || kind.ll) ? rd_word : '0;
      rsp_sc_ok <= sc_pass;
    end
  end

endmodule

// File: rtl/llsc_home_unit_chk.sv
module llsc_home_unit_chk #(
  parameter int ID_W    = 3,
  parameter int ADDR_W  = 6,
  parameter int TIMEOUT = 256,
  localparam int CNT_W  = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ID_W-1:0]   req_id,
  input logic              rsp_valid,
  input logic [ID_W-1:0]   rsp_id,
  input logic              rsp_sc_ok,
  input logic              mem_we,
  input logic              resv_valid,
  input logic [ID_W-1:0]   resv_id,
  input logic [ADDR_W-1:0] resv_addr,
  input logic [CNT_W-1:0]  resv_count,
  input logic              ll_accept,
  input logic              ll_refuse,
  input logic              sc_pass,
  input logic              sc_fail,
  input logic              st_kill,
  input logic              tmo_fire
);

  assert_ll_takes_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ll_accept |=> resv_valid && resv_id == $past(req_id) && resv_count == '0);

  assert_ll_no_overwrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ll_refuse |=> resv_valid && $stable(resv_id) && $stable(resv_addr));

  assert_sc_pass_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sc_pass |=> rsp_sc_ok && !resv_valid);

  assert_sc_fail_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sc_fail |-> !mem_we);

  assert_store_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st_kill |=> !resv_valid);

  assert_age_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resv_valid |-> int'(resv_count) < TIMEOUT);

  assert_expiry_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fire && !ll_accept |=> !resv_valid);

  assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid && rsp_id == $past(req_id));

  assert_no_idle_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_single_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ll_accept, ll_refuse, sc_pass, sc_fail, st_kill}));

endmodule

bind llsc_home_unit llsc_home_unit_chk #(.ID_W(ID_W), .ADDR_W(ADDR_W), .TIMEOUT(TIMEOUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_id     (req_id),
  .rsp_valid  (rsp_valid),
  .rsp_id     (rsp_id),
  .rsp_sc_ok  (rsp_sc_ok),
  .mem_we     (mem_we),
  .resv_valid (resv_valid),
  .resv_id    (resv_id),
  .resv_addr  (resv_addr),
  .resv_count (resv_count),
  .ll_accept  (ll_accept),
  .ll_refuse  (ll_refuse),
  .sc_pass    (sc_pass),
  .sc_fail    (sc_fail),
  .st_kill    (st_kill),
  .tmo_fire   (tmo_fire)
);

// File: tb/test_llsc_home_unit.sv
`timescale 1ns/1ps
module test_llsc_home_unit;

  localparam int ID_W = 3, ADDR_W = 6, DATA_W = 16, TMO = 256;

  typedef struct packed {
    logic [1:0]        op;
    logic [ID_W-1:0]   id;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wd;
    logic              ok;
    logic [DATA_W-1:0] rd;
    logic              we;
  } vec_t;

  localparam int NV = 16;
  // op: 0 load, 1 load-linked, 2 store-conditional, 3 store
  localparam vec_t VEC [NV] = '{
    '{2'd3, 3'd1, 6'd5,  16'h1111, 1'b0, 16'h0000, 1'b1}, // R6 plain store writes
    '{2'd1, 3'd2, 6'd5,  16'h0000, 1'b0, 16'h1111, 1'b0}, // R2 LL takes free slot
    '{2'd1, 3'd3, 6'd9,  16'h0000, 1'b0, 16'h0000, 1'b0}, // R3 R11 refused, data R1 zero
    '{2'd2, 3'd3, 6'd9,  16'h2222, 1'b0, 16'h0000, 1'b0}, // R3 R5 refused requester fails
    '{2'd0, 3'd4, 6'd5,  16'h0000, 1'b0, 16'h1111, 1'b0}, // R10 load, no effect
    '{2'd2, 3'd2, 6'd5,  16'h3333, 1'b1, 16'h0000, 1'b1}, // R4 owner succeeds
    '{2'd2, 3'd2, 6'd5,  16'h4444, 1'b0, 16'h0000, 1'b0}, // R4 released, now fails
    '{2'd0, 3'd0, 6'd5,  16'h0000, 1'b0, 16'h3333, 1'b0}, // R4 write landed
    '{2'd1, 3'd3, 6'd9,  16'h0000, 1'b0, 16'h0000, 1'b0}, // R2 accepted
    '{2'd3, 3'd1, 6'd10, 16'h5555, 1'b0, 16'h0000, 1'b1}, // R6 other address keeps slot
    '{2'd2, 3'd3, 6'd10, 16'h6666, 1'b0, 16'h0000, 1'b0}, // R5 wrong address fails
    '{2'd2, 3'd3, 6'd9,  16'h7777, 1'b1, 16'h0000, 1'b1}, // R5 R6 slot survived
    '{2'd1, 3'd4, 6'd9,  16'h0000, 1'b0, 16'h7777, 1'b0}, // R2
    '{2'd3, 3'd5, 6'd9,  16'h8888, 1'b0, 16'h0000, 1'b1}, // R6 store hits reserved
    '{2'd2, 3'd4, 6'd9,  16'h9999, 1'b0, 16'h0000, 1'b0}, // R6 slot cleared
    '{2'd0, 3'd6, 6'd9,  16'h0000, 1'b0, 16'h8888, 1'b0}  // R5 R10 failed SC no write
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [1:0]        req_op = '0;
  logic [ID_W-1:0]   req_id = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              rsp_valid, rsp_sc_ok, mem_we;
  logic [ID_W-1:0]   rsp_id;
  logic [1:0]        rsp_op;
  logic [DATA_W-1:0] rsp_rdata, mem_wdata;
  logic [ADDR_W-1:0] mem_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  llsc_home_unit #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT(TMO)) i_llsc_home_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_id(req_id),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
    .rsp_op(rsp_op), .rsp_rdata(rsp_rdata), .rsp_sc_ok(rsp_sc_ok), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  task automatic chk(input bit good, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!good) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge; return at the next falling edge with the response visible.
  task automatic issue(input logic [1:0] op, input logic [ID_W-1:0] id,
                       input logic [ADDR_W-1:0] addr, input logic [DATA_W-1:0] wd);
    req_valid = 1'b1; req_op = op; req_id = id; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in and right after reset
    chk(rsp_valid === 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 0);
    chk(mem_we === 1'b0, "R1 mem_we in reset", 32'(mem_we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 0);

    for (int i = 0; i < NV; i++) begin
      req_valid = 1'b1; req_op = VEC[i].op; req_id = VEC[i].id;
      req_addr = VEC[i].addr; req_wdata = VEC[i].wd;
      #1;
      chk(mem_we === VEC[i].we, $sformatf("R4 R6 table row %0d mem_we", i), 32'(mem_we), 32'(VEC[i].we));
      if (VEC[i].we)
        chk(mem_addr === VEC[i].addr && mem_wdata === VEC[i].wd,
            $sformatf("R4 table row %0d write data", i), 32'(mem_wdata), 32'(VEC[i].wd));
      @(negedge clk);
      chk(rsp_valid === 1'b1 && rsp_id === VEC[i].id && rsp_op === VEC[i].op,
          $sformatf("R9 table row %0d response tag", i), 32'(rsp_id), 32'(VEC[i].id));
      chk(rsp_sc_ok === VEC[i].ok, $sformatf("R4 R5 table row %0d sc verdict", i),
          32'(rsp_sc_ok), 32'(VEC[i].ok));
      chk(rsp_rdata === VEC[i].rd, $sformatf("R2 R9 table row %0d read data", i),
          32'(rsp_rdata), 32'(VEC[i].rd));
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R9 no request no response", 32'(rsp_valid), 0);

    // R7: SC exactly TIMEOUT edges after LL succeeds
    issue(2'd1, 3'd1, 6'd20, '0);
    idle(TMO - 1);
    issue(2'd2, 3'd1, 6'd20, 16'hA0A0);
    chk(rsp_sc_ok === 1'b1, "R7 sc at TIMEOUT edges", 32'(rsp_sc_ok), 1);

    // R7: SC TIMEOUT+1 edges after LL fails and writes nothing
    issue(2'd1, 3'd1, 6'd21, '0);
    idle(TMO);
    req_valid = 1'b1; req_op = 2'd2; req_id = 3'd1; req_addr = 6'd21; req_wdata = 16'hB0B0;
    #1;
    chk(mem_we === 1'b0, "R7 expired sc no write strobe", 32'(mem_we), 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_sc_ok === 1'b0, "R7 sc at TIMEOUT+1 edges", 32'(rsp_sc_ok), 0);
    issue(2'd0, 3'd1, 6'd21, '0);
    chk(rsp_rdata === 16'h0000, "R7 expired sc left word", 32'(rsp_rdata), 0);

    // R8: LL on the expiry edge from another requester is accepted
    issue(2'd1, 3'd1, 6'd22, '0);
    idle(TMO - 1);
    issue(2'd1, 3'd2, 6'd23, '0);
    issue(2'd2, 3'd1, 6'd22, 16'hC0C0);
    chk(rsp_sc_ok === 1'b0, "R8 old owner loses slot", 32'(rsp_sc_ok), 0);
    issue(2'd2, 3'd2, 6'd23, 16'hD0D0);
    chk(rsp_sc_ok === 1'b1, "R8 new owner holds slot", 32'(rsp_sc_ok), 1);
    issue(2'd0, 3'd2, 6'd23, '0);
    chk(rsp_rdata === 16'hD0D0, "R8 new owner write landed", 32'(rsp_rdata), 32'hD0D0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule